// File: doc/BRIEF.md
# Logarithmic-Domain Multiply/Divide Unit

This unit multiplies or divides two numbers held in a logarithmic number format. Each word has three parts. A two-bit class code marks the word as zero, ordinary, infinite or not-a-number. A sign bit follows. The rest is the base-2 logarithm of the magnitude, held as a signed two's-complement fixed-point value with `INT_W` integer bits and `FRAC_W` fraction bits. A log value below zero stands for a magnitude under 1.0.

A multiply adds the two logarithms and a divide subtracts the divisor's logarithm from the dividend's, so no mantissa multiplier or divider is needed. The log field cannot express zero, so zero, infinity and not-a-number travel in the class code. They combine in the usual floating-point manner.

A single register stage captures each result. An output valid pulse marks the cycle in which that result appears.

Top module: `lnsmd_top`

## Requirements
- R1: A result appears on `result` with `outValid` high exactly one clock after the edge that samples `inValid` high; `outValid` is low one clock after any edge that samples `inValid` low.
- R2: Multiply of two ordinary operands (class 01) gives class 01 with log field equal to the two's-complement sum of the operand log fields when that sum fits in `INT_W+FRAC_W` bits.
- R3: Divide (`divMode`=1) of two ordinary operands gives class 01 with log field equal to dividend log minus divisor log when the difference fits.
- R4: The result sign is the XOR of the operand signs for every mode and class combination.
- R5: If the exact log result of two ordinary operands exceeds the largest representable value, the result class is infinity (10).
- R6: If the exact log result of two ordinary operands falls below the most negative representable value, the result class is zero (00).
- R7: Any operand of class 11 (not-a-number) gives class 11.
- R8: In multiply, zero with infinity in either order gives class 11. Otherwise, a zero operand gives class 00, and an infinite operand gives class 10.
- R9: In divide, 0/0 and inf/inf give class 11. An ordinary or infinite dividend over zero gives 10. A zero dividend over an ordinary or infinite divisor gives 00. Infinity over ordinary gives 10. Ordinary over infinity gives 00.
- R10: Whenever the result class is not 01, the log field of `result` is all zeros.
- R11: While `inValid` is low, `result` keeps its last value regardless of operand or mode changes.
- R12: During reset `outValid` is low and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands and mode are valid this cycle |
| divMode | input | 1 | 0 = multiply, 1 = divide (opA / opB) |
| opA | input | INT_W+FRAC_W+3 | First operand / dividend: {class[1:0], sign, log} |
| opB | input | INT_W+FRAC_W+3 | Second operand / divisor, same packing |
| outValid | output | 1 | Result valid |
| result | output | INT_W+FRAC_W+3 | Product or quotient, same packing |

## Verification
Every result is due one clock after the edge that captures its operands, because the only register on the path is the output register. The bench therefore drives operands on a falling edge and samples `result` and `outValid` on the next falling edge, which falls after exactly one capturing edge. Hold behaviour is sampled one and two falling edges later, with the operands scrambled and `inValid` low, and `outValid` must read low there. Expected words come from integer arithmetic with an explicit range test, not from the carry-based overflow detection used in the design.

// File: rtl/lnsmd_pkg.sv
package lnsmd_pkg;

  typedef enum logic [1:0] {
    FLG_ZERO = 2'b00,
    FLG_NORM = 2'b01,
    FLG_INF  = 2'b10,
    FLG_NAN  = 2'b11
  } flag_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic capture;
    logic divSel;
  } strobe_t;

endpackage

// File: rtl/lnsmd_ctrl.sv
module lnsmd_ctrl
  import lnsmd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    divMode,
  output strobe_t strobes,
  output logic    outValid
);

  always_comb begin
    strobes.capture = inValid;
    strobes.divSel  = divMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/lnsmd_logadd.sv
module lnsmd_logadd #(
  parameter int LOG_W = 18
) (
  input  logic [LOG_W-1:0] lhs,
  input  logic [LOG_W-1:0] rhs,
  input  logic             sub,
  output logic [LOG_W-1:0] sum,
  output logic             posOvf,
  output logic             negOvf
);

  localparam int MSB = LOG_W - 1;

  logic [LOG_W-1:0] rhsEff;
  logic [LOG_W-1:0] lowSum;
  logic             carryIn;
  logic             carryOut;
  logic             ovf;

  always_comb begin
    rhsEff   = sub ? ~rhs : rhs;
    // low part carries into the sign position through lowSum[MSB]
    lowSum   = {1'b0, lhs[MSB-1:0]} + {1'b0, rhsEff[MSB-1:0]}
             + {{(LOG_W-1){1'b0}}, sub};
    carryIn  = lowSum[MSB];
    carryOut = (lhs[MSB] & rhsEff[MSB]) | (carryIn & (lhs[MSB] ^ rhsEff[MSB]));
    sum      = {lhs[MSB] ^ rhsEff[MSB] ^ carryIn, lowSum[MSB-1:0]};
    ovf      = carryIn ^ carryOut;
    posOvf   = ovf & ~carryOut;
    negOvf   = ovf & carryOut;
  end

endmodule

// File: rtl/lnsmd_datapath.sv
module lnsmd_datapath
  import lnsmd_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strobes,
  input  logic [INT_W+FRAC_W+2:0]   opA,
  input  logic [INT_W+FRAC_W+2:0]   opB,
  output logic [INT_W+FRAC_W+2:0]   result
);

  localparam int LOG_W  = INT_W + FRAC_W;
  localparam int WORD_W = LOG_W + 3;
  localparam int SGN_B  = LOG_W;

  flag_e            flagA, flagB, resFlag;
  logic [LOG_W-1:0] logSum;
  logic             posOvf, negOvf;
  logic             resSign;
  logic [WORD_W-1:0] nextWord;

  lnsmd_logadd #(.LOG_W(LOG_W)) u_add (
    .lhs    (opA[LOG_W-1:0]),
    .rhs    (opB[LOG_W-1:0]),
    .sub    (strobes.divSel),
    .sum    (logSum),
    .posOvf (posOvf),
    .negOvf (negOvf)
  );

  always_comb begin
    flagA   = flag_e'(opA[WORD_W-1 -: 2]);
    flagB   = flag_e'(opB[WORD_W-1 -: 2]);
    resSign = opA[SGN_B] ^ opB[SGN_B];
    resFlag = FLG_NORM;
    if (flagA == FLG_NAN || flagB == FLG_NAN) begin
      resFlag = FLG_NAN;
    end else if (!strobes.divSel) begin
      if ((flagA == FLG_ZERO && flagB == FLG_INF) ||
          (flagA == FLG_INF  && flagB == FLG_ZERO))
        resFlag = FLG_NAN;
      else if (flagA == FLG_ZERO || flagB == FLG_ZERO)
        resFlag = FLG_ZERO;
      else if (flagA == FLG_INF || flagB == FLG_INF)
        resFlag = FLG_INF;
      else if (posOvf)
        resFlag = FLG_INF;
      else if (negOvf)
        resFlag = FLG_ZERO;
    end else begin
      if ((flagA == FLG_ZERO && flagB == FLG_ZERO) ||
          (flagA == FLG_INF  && flagB == FLG_INF))
        resFlag = FLG_NAN;
      else if (flagB == FLG_ZERO)
        resFlag = FLG_INF;
      else if (flagA == FLG_ZERO)
        resFlag = FLG_ZERO;
      else if (flagA == FLG_INF)
        resFlag = FLG_INF;
      else if (flagB == FLG_INF)
        resFlag = FLG_ZERO;
      else if (posOvf)
        resFlag = FLG_INF;
      else if (negOvf)
        resFlag = FLG_ZERO;
    end
    nextWord = {resFlag, resSign, (resFlag == FLG_NORM) ? logSum : {LOG_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                result <= '0;
    else if (strobes.capture) result <= nextWord;
  end

endmodule

// File: rtl/lnsmd_top.sv
module lnsmd_top
  import lnsmd_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic                    divMode,
  input  logic [INT_W+FRAC_W+2:0] opA,
  input  logic [INT_W+FRAC_W+2:0] opB,
  output logic                    outValid,
  output logic [INT_W+FRAC_W+2:0] result
);

  strobe_t strobes;

  lnsmd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .divMode  (divMode),
    .strobes  (strobes),
    .outValid (outValid)
  );

  lnsmd_datapath #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .result  (result)
  );

endmodule

// File: rtl/lnsmd_chk.sv
module lnsmd_chk #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 10
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic [INT_W+FRAC_W+2:0] opA,
  input logic [INT_W+FRAC_W+2:0] opB,
  input logic                    outValid,
  input logic [INT_W+FRAC_W+2:0] result
);

  localparam int LOG_W  = INT_W + FRAC_W;
  localparam int WORD_W = LOG_W + 3;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_no_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_sign_xor_R4: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> result[LOG_W] == ($past(opA[LOG_W]) ^ $past(opB[LOG_W])));

  assert_nan_in_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opA[WORD_W-1 -: 2] == 2'b11 || opB[WORD_W-1 -: 2] == 2'b11))
      |=> result[WORD_W-1 -: 2] == 2'b11);

  assert_special_log_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && result[WORD_W-1 -: 2] != 2'b01) |-> result[LOG_W-1:0] == '0);

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));

endmodule

bind lnsmd_top lnsmd_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opA      (opA),
  .opB      (opB),
  .outValid (outValid),
  .result   (result)
);

// File: tb/lnsmd_top_tb.sv
`timescale 1ns/1ps
module lnsmd_top_tb;

  localparam int INT_W  = 8;
  localparam int FRAC_W = 10;
  localparam int LOG_W  = INT_W + FRAC_W;
  localparam int WORD_W = LOG_W + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic divMode = 1'b0;
  logic [WORD_W-1:0] opA = '0;
  logic [WORD_W-1:0] opB = '0;
  logic outValid;
  logic [WORD_W-1:0] result;

  int total = 0;
  int failed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lnsmd_top #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .divMode(divMode),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result)
  );

  function automatic logic [WORD_W-1:0] mk(logic [1:0] f, logic s, longint lv);
    return {f, s, LOG_W'(lv)};
  endfunction

  // expected word built from the requirements with plain integer range tests
  function automatic logic [WORD_W-1:0] model(logic [WORD_W-1:0] a,
                                              logic [WORD_W-1:0] b, logic dv);
    logic [1:0] fa, fb, f;
    logic s;
    longint la, lb, r, maxV, minV;
    fa = a[WORD_W-1 -: 2];
    fb = b[WORD_W-1 -: 2];
    s  = a[LOG_W] ^ b[LOG_W];
    la = longint'(signed'(a[LOG_W-1:0]));
    lb = longint'(signed'(b[LOG_W-1:0]));
    r  = dv ? la - lb : la + lb;
    maxV = (longint'(1) <<< (LOG_W-1)) - 1;
    minV = -(longint'(1) <<< (LOG_W-1));
    if (fa == 2'b11 || fb == 2'b11) f = 2'b11;
    else if (!dv) begin
      if ((fa == 2'b00 && fb == 2'b10) || (fa == 2'b10 && fb == 2'b00)) f = 2'b11;
      else if (fa == 2'b00 || fb == 2'b00) f = 2'b00;
      else if (fa == 2'b10 || fb == 2'b10) f = 2'b10;
      else if (r > maxV) f = 2'b10;
      else if (r < minV) f = 2'b00;
      else f = 2'b01;
    end else begin
      if ((fa == 2'b00 && fb == 2'b00) || (fa == 2'b10 && fb == 2'b10)) f = 2'b11;
      else if (fb == 2'b00) f = 2'b10;
      else if (fa == 2'b00) f = 2'b00;
      else if (fa == 2'b10) f = 2'b10;
      else if (fb == 2'b10) f = 2'b00;
      else if (r > maxV) f = 2'b10;
      else if (r < minV) f = 2'b00;
      else f = 2'b01;
    end
    return {f, s, (f == 2'b01) ? LOG_W'(r) : {LOG_W{1'b0}}};
  endfunction

  task automatic check(bit ok, string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one operation on a falling edge, sample one clock later
  task automatic runOp(logic [WORD_W-1:0] a, logic [WORD_W-1:0] b, logic dv, string req);
    logic [WORD_W-1:0] exp;
    exp = model(a, b, dv);
    @(negedge clk);
    inValid = 1'b1; opA = a; opB = b; divMode = dv;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, {req, " R1 valid"}, WORD_W'(outValid), WORD_W'(1));
    check(result == exp, req, result, exp);
  endtask

  task automatic t_reset();
    check(outValid == 1'b0, "R12 valid in reset", WORD_W'(outValid), '0);
    check(result == '0, "R12 result in reset", result, '0);
  endtask

  task automatic t_mulNormal();
    runOp(mk(2'b01, 1'b0, 1024),  mk(2'b01, 1'b1, 2048), 1'b0, "R2 mul pos R4");
    runOp(mk(2'b01, 1'b1, -5000), mk(2'b01, 1'b1, 3000), 1'b0, "R2 mul mixed R4");
    runOp(mk(2'b01, 1'b0, 65536), mk(2'b01, 1'b0, 65535), 1'b0, "R2 mul top edge");
    runOp(mk(2'b01, 1'b0, -65536), mk(2'b01, 1'b1, -65536), 1'b0, "R2 mul bottom edge");
  endtask

  task automatic t_divNormal();
    runOp(mk(2'b01, 1'b0, 3000),  mk(2'b01, 1'b1, -5000), 1'b1, "R3 div R4");
    runOp(mk(2'b01, 1'b1, -1000), mk(2'b01, 1'b1, 2000),  1'b1, "R3 div neg");
    runOp(mk(2'b01, 1'b0, 777),   mk(2'b01, 1'b0, 777),   1'b1, "R3 div equal");
  endtask

  task automatic t_overflow();
    runOp(mk(2'b01, 1'b0, 100000), mk(2'b01, 1'b1, 50000), 1'b0, "R5 mul ovf");
    check(result[LOG_W-1:0] == '0, "R10 log cleared on inf", result, '0);
    runOp(mk(2'b01, 1'b0, 100000), mk(2'b01, 1'b0, -50000), 1'b1, "R5 div ovf");
  endtask

  task automatic t_underflow();
    runOp(mk(2'b01, 1'b1, -100000), mk(2'b01, 1'b0, 50000), 1'b1, "R6 div unf");
    check(result[LOG_W-1:0] == '0, "R10 log cleared on zero", result, '0);
    runOp(mk(2'b01, 1'b0, -100000), mk(2'b01, 1'b0, -40000), 1'b0, "R6 mul unf");
  endtask

  task automatic t_nan();
    runOp(mk(2'b11, 1'b0, 0),    mk(2'b01, 1'b1, 500), 1'b0, "R7 nan a mul");
    runOp(mk(2'b01, 1'b1, 1234), mk(2'b11, 1'b1, 0),   1'b1, "R7 nan b div");
    check(result[LOG_W-1:0] == '0, "R10 log cleared on nan", result, '0);
  endtask

  task automatic t_mulSpecials();
    runOp(mk(2'b00, 1'b0, 0),   mk(2'b10, 1'b1, 0),   1'b0, "R8 zero x inf");
    runOp(mk(2'b10, 1'b0, 0),   mk(2'b00, 1'b0, 0),   1'b0, "R8 inf x zero");
    runOp(mk(2'b00, 1'b1, 0),   mk(2'b01, 1'b0, 900), 1'b0, "R8 zero x norm");
    runOp(mk(2'b01, 1'b1, -70), mk(2'b10, 1'b1, 0),   1'b0, "R8 norm x inf");
    runOp(mk(2'b10, 1'b0, 0),   mk(2'b10, 1'b1, 0),   1'b0, "R8 inf x inf");
  endtask

  task automatic t_divSpecials();
    runOp(mk(2'b00, 1'b0, 0),   mk(2'b00, 1'b0, 0),   1'b1, "R9 0/0");
    runOp(mk(2'b10, 1'b1, 0),   mk(2'b10, 1'b0, 0),   1'b1, "R9 inf/inf");
    runOp(mk(2'b01, 1'b0, 40),  mk(2'b00, 1'b1, 0),   1'b1, "R9 x/0");
    runOp(mk(2'b10, 1'b0, 0),   mk(2'b00, 1'b0, 0),   1'b1, "R9 inf/0");
    runOp(mk(2'b00, 1'b1, 0),   mk(2'b01, 1'b1, 10),  1'b1, "R9 0/x");
    runOp(mk(2'b10, 1'b1, 0),   mk(2'b01, 1'b0, 10),  1'b1, "R9 inf/x");
    runOp(mk(2'b01, 1'b0, 10),  mk(2'b10, 1'b1, 0),   1'b1, "R9 x/inf");
  endtask

  task automatic t_hold();
    logic [WORD_W-1:0] kept;
    runOp(mk(2'b01, 1'b0, 1500), mk(2'b01, 1'b1, 250), 1'b0, "R2 before hold");
    kept = result;
    opA = mk(2'b11, 1'b1, 99); opB = mk(2'b00, 1'b0, 5); divMode = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 idle valid low", WORD_W'(outValid), '0);
    check(result == kept, "R11 hold 1", result, kept);
    opA = mk(2'b01, 1'b0, 3); divMode = 1'b0;
    @(negedge clk);
    check(result == kept, "R11 hold 2", result, kept);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_mulNormal();
    t_divNormal();
    t_overflow();
    t_underflow();
    t_nan();
    t_mulSpecials();
    t_divSpecials();
    t_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      failed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule